// File: doc/BRIEF.md
# Pixel Hit Derandomizer and Packetizer

This block sits on a front-end chip that serves many pixel channels. Each channel can raise a one-cycle hit strobe together with an 8-bit charge value at any time. The block stamps every hit with the value of a free-running coarse time counter, parks it in a small per-channel queue, and then moves queued hits one at a time into a deep shared queue. Every hit leaves the block as a self-describing 64-bit word that carries the pixel number, the timestamp and the charge.

Bursts are absorbed in two stages. The per-channel queues take short bursts on a single pixel. The shared queue takes the larger bursts seen when a track crosses many pixels of the chip at once. A sync input resets the time counter so that all chips on a board share one time origin. Hits that find their channel queue full are discarded and counted in a saturating counter. The consumer reads words through a valid/ready handshake.

Top module: `hit_packer`

## Requirements
- R1: While reset is asserted and right after it, no word is offered (out_valid_o low), the drop count reads zero and the time counter starts at zero.
- R2: An output word holds the charge in bits [7:0], the timestamp zero-extended to 32 bits in bits [39:8] and the pixel number in bits [59:40]. Bits [63:60] are always zero.
- R3: The time counter advances by one on every clock and wraps silently from all ones to zero (modulo 2^TS_W).
- R4: A sync pulse makes the counter read zero in the following cycle. A hit strobed in the same cycle as sync still gets the value from before the clear.
- R5: The timestamp in a word is the counter value of the cycle in which the hit strobe was high, not the value at the time the word moves between queues.
- R6: The pixel number is the chip address (chip_addr_i) in its upper bits followed by the channel index in its lowest log2(NUM_CH) bits.
- R7: Each channel queue holds CH_DEPTH hits, and the words of one channel leave in the order their strobes arrived.
- R8: At most one word per clock moves from a non-empty channel queue to the shared queue, and none while the shared queue is full. The choice rotates: after reset the search starts at channel 0, and after each grant it starts at the channel after the one granted.
- R9: The shared queue holds FIFO_DEPTH words. A word is consumed on a clock where out_valid_o and out_ready_i are both high. While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_word_o does not change.
- R10: A strobe on a channel whose queue is full at that clock is discarded. Each discarded hit adds one to drop_cnt_o, which stops at its maximum value. Strobes on other channels are unaffected.
- R11: When all queues are empty, a hit strobed before clock edge k is offered on the output after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the timestamp tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Synchronous clear of the time counter |
| chip_addr_i | input | 20-log2(NUM_CH) | Chip address placed in the upper pixel-number bits |
| hit_stb_i | input | NUM_CH | Per-channel one-cycle hit strobe |
| hit_chg_i | input | 8*NUM_CH | Per-channel charge, channel c in bits [8c+7:8c] |
| out_valid_o | output | 1 | A word is available |
| out_ready_i | input | 1 | Consumer accepts the word |
| out_word_o | output | 64 | Formatted hit word |
| drop_cnt_o | output | DROP_W | Saturating count of discarded hits |

## Verification
The bench builds the block with 4 channels, 4-entry channel queues, an 8-word shared queue, an 8-bit time counter and a 3-bit drop counter. The narrow counter brings the timestamp wrap within a few hundred cycles. The small shared queue lets a stalled consumer fill it and then fill a channel queue, so drops, independence of other channels and counter saturation all occur in one short burst. Four channels keep the rotating grant order short enough to check exactly, including one case where a fixed-priority order would give a different result.

// File: rtl/hp_pkg.sv
package hp_pkg;
    localparam int PIX_W  = 20;
    localparam int TSF_W  = 32;
    localparam int CHG_W  = 8;
    localparam int RSV_W  = 4;
    localparam int WORD_W = RSV_W + PIX_W + TSF_W + CHG_W;

    typedef logic [WORD_W-1:0] hit_word_t;

    // Packs one hit into the fixed output layout, reserved top bits zero.
    function automatic hit_word_t build_word(
        input logic [PIX_W-1:0] pix,
        input logic [TSF_W-1:0] ts,
        input logic [CHG_W-1:0] chg
    );
        return {{RSV_W{1'b0}}, pix, ts, chg};
    endfunction
endpackage

// File: rtl/hp_ts_counter.sv
module hp_ts_counter #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sync_i,
    output logic [TS_W-1:0] ts_o
);
    typedef struct packed {
        logic [TS_W-1:0] ts;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (sync_i) begin
            s_d.ts = '0;
        end else begin
            s_d.ts = s_q.ts + TS_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ts_o = s_q.ts;
endmodule

// File: rtl/hp_chan_buf.sv
module hp_chan_buf #(
    parameter int DEPTH = 4,
    parameter int W     = 40
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         nonempty_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wr;
        logic [PTR_W-1:0]        rd;
        logic [CNT_W-1:0]        cnt;
    } st_t;

    st_t  s_d, s_q;
    logic do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push_i && (s_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (s_q.cnt != '0);
        if (do_push) begin
            s_d.mem[s_q.wr] = data_i;
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign data_o     = s_q.mem[s_q.rd];
    assign nonempty_o = (s_q.cnt != '0);
    assign full_o     = (s_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/hp_rr_arb.sv
module hp_rr_arb #(
    parameter int N = 64,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    input  logic             en_i,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
    } st_t;

    st_t              s_d, s_q;
    logic             found;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] cand;

    always_comb begin
        s_d     = s_q;
        found   = 1'b0;
        pick    = '0;
        cand    = '0;
        grant_o = '0;
        // search from the pointer, wrapping once around all channels
        for (int i = 0; i < N; i++) begin
            cand = IDX_W'((int'(s_q.ptr) + i) % N);
            if (!found && en_i && req_i[cand]) begin
                found = 1'b1;
                pick  = cand;
            end
        end
        if (found) begin
            grant_o[pick] = 1'b1;
            s_d.ptr = (pick == IDX_W'(N - 1)) ? '0 : pick + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign idx_o   = pick;
    assign valid_o = found;
endmodule

// File: rtl/hp_sync_fifo.sv
module hp_sync_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t          s_d, s_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         do_push, do_pop;

    always_comb begin
        s_d     = s_q;
        do_push = push_i && (s_q.cnt != CNT_W'(DEPTH));
        do_pop  = pop_i && (s_q.cnt != '0);
        if (do_push) begin
            s_d.wr = (s_q.wr == PTR_W'(DEPTH - 1)) ? '0 : s_q.wr + PTR_W'(1);
        end
        if (do_pop) begin
            s_d.rd = (s_q.rd == PTR_W'(DEPTH - 1)) ? '0 : s_q.rd + PTR_W'(1);
        end
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // storage carries no reset; only the pointers do
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem_q[s_q.wr] <= data_i;
        end
    end

    assign data_o  = mem_q[s_q.rd];
    assign empty_o = (s_q.cnt == '0);
    assign full_o  = (s_q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/hit_packer.sv
module hit_packer #(
    parameter int NUM_CH     = 64,
    parameter int CH_DEPTH   = 4,
    parameter int FIFO_DEPTH = 1024,
    parameter int TS_W       = 32,
    parameter int DROP_W     = 16,
    localparam int CH_IDX_W  = $clog2(NUM_CH),
    localparam int ADDR_W    = hp_pkg::PIX_W - CH_IDX_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           sync_i,
    input  logic [ADDR_W-1:0]              chip_addr_i,
    input  logic [NUM_CH-1:0]              hit_stb_i,
    input  logic [NUM_CH*hp_pkg::CHG_W-1:0] hit_chg_i,
    output logic                           out_valid_o,
    input  logic                           out_ready_i,
    output logic [hp_pkg::WORD_W-1:0]      out_word_o,
    output logic [DROP_W-1:0]              drop_cnt_o
);
    import hp_pkg::*;

    localparam int ENT_W = TS_W + CHG_W;
    localparam int SUM_W = DROP_W + CH_IDX_W + 1;

    logic [TS_W-1:0]     ts_w;
    logic [NUM_CH-1:0]   ch_full;
    logic [NUM_CH-1:0]   ch_ne;
    logic [ENT_W-1:0]    ch_data [NUM_CH];
    logic [NUM_CH-1:0]   grant_w;
    logic [CH_IDX_W-1:0] gnt_idx;
    logic                gnt_vld;
    logic                fifo_full;
    logic                fifo_empty;
    logic [ENT_W-1:0]    sel_ent;
    hit_word_t           new_word;
    logic [NUM_CH-1:0]   drop_vec;

    hp_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_i (sync_i),
        .ts_o   (ts_w)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic             push_c;
        logic [ENT_W-1:0] ent_c;

        // stamp with the counter value of the strobe cycle
        assign push_c = hit_stb_i[c] & ~ch_full[c];
        assign ent_c  = {ts_w, hit_chg_i[c*CHG_W +: CHG_W]};

        hp_chan_buf #(.DEPTH(CH_DEPTH), .W(ENT_W)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_i     (push_c),
            .data_i     (ent_c),
            .pop_i      (grant_w[c]),
            .data_o     (ch_data[c]),
            .nonempty_o (ch_ne[c]),
            .full_o     (ch_full[c])
        );
    end

    hp_rr_arb #(.N(NUM_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (ch_ne),
        .en_i    (~fifo_full),
        .grant_o (grant_w),
        .idx_o   (gnt_idx),
        .valid_o (gnt_vld)
    );

    assign sel_ent  = ch_data[gnt_idx];
    assign new_word = build_word({chip_addr_i, gnt_idx},
                                 TSF_W'(sel_ent[ENT_W-1:CHG_W]),
                                 sel_ent[CHG_W-1:0]);

    hp_sync_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (gnt_vld),
        .data_i  (new_word),
        .pop_i   (out_ready_i),
        .data_o  (out_word_o),
        .empty_o (fifo_empty),
        .full_o  (fifo_full)
    );

    assign out_valid_o = ~fifo_empty;

    // saturating drop accounting
    typedef struct packed {
        logic [DROP_W-1:0] drops;
    } st_t;

    st_t        s_d, s_q;
    logic [SUM_W-1:0] sum;

    assign drop_vec = hit_stb_i & ch_full;

    always_comb begin
        s_d = s_q;
        sum = SUM_W'(s_q.drops) + SUM_W'($countones(drop_vec));
        if (sum > SUM_W'({DROP_W{1'b1}})) begin
            s_d.drops = {DROP_W{1'b1}};
        end else begin
            s_d.drops = sum[DROP_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign drop_cnt_o = s_q.drops;
endmodule

// File: rtl/hp_checker.sv
module hp_checker #(
    parameter int NUM_CH = 64,
    parameter int TS_W   = 32,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sync_i,
    input logic [NUM_CH-1:0] stb_i,
    input logic [NUM_CH-1:0] ch_full_i,
    input logic [TS_W-1:0]   ts_i,
    input logic [NUM_CH-1:0] grant_i,
    input logic              fifo_full_i,
    input logic              vld_i,
    input logic              rdy_i,
    input logic [63:0]       word_i,
    input logic [DROP_W-1:0] drops_i
);
    p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        vld_i |-> (word_i[63:60] == 4'b0000));

    p_ts_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> (ts_i == TS_W'($past(ts_i) + TS_W'(1))));

    p_sync_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_i |=> (ts_i == '0));

    p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_i));

    p_full_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_i |-> (grant_i == '0));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !rdy_i) |=> (vld_i && $stable(word_i)));

    p_drop_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_i & ch_full_i) != '0) |=> (drops_i != '0));

    p_drop_still_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((stb_i & ch_full_i) == '0) |=> $stable(drops_i));
endmodule

bind hit_packer hp_checker #(
    .NUM_CH (NUM_CH),
    .TS_W   (TS_W),
    .DROP_W (DROP_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_i),
    .stb_i       (hit_stb_i),
    .ch_full_i   (ch_full),
    .ts_i        (ts_w),
    .grant_i     (grant_w),
    .fifo_full_i (fifo_full),
    .vld_i       (out_valid_o),
    .rdy_i       (out_ready_i),
    .word_i      (out_word_o),
    .drops_i     (drop_cnt_o)
);

// File: tb/hit_packer_tb_top.sv
module hit_packer_tb_top;
    localparam int CLK_P      = 10;
    localparam int NUM_CH     = 4;
    localparam int CH_DEPTH   = 4;
    localparam int FIFO_DEPTH = 8;
    localparam int TS_W       = 8;
    localparam int DROP_W     = 3;
    localparam int CH_IDX_W   = $clog2(NUM_CH);
    localparam int ADDR_W     = 20 - CH_IDX_W;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  sync = 1'b0;
    logic [ADDR_W-1:0]     cfg_addr = 18'h2A5C3;
    logic [NUM_CH-1:0]     stb = '0;
    logic [NUM_CH*8-1:0]   chg = '0;
    logic                  vld;
    logic                  rdy = 1'b1;
    logic [63:0]           word;
    logic [DROP_W-1:0]     drops;

    always #(CLK_P/2) clk = ~clk;

    hit_packer #(
        .NUM_CH(NUM_CH), .CH_DEPTH(CH_DEPTH), .FIFO_DEPTH(FIFO_DEPTH),
        .TS_W(TS_W), .DROP_W(DROP_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_i(sync), .chip_addr_i(cfg_addr),
        .hit_stb_i(stb), .hit_chg_i(chg), .out_valid_o(vld),
        .out_ready_i(rdy), .out_word_o(word), .drop_cnt_o(drops)
    );

    typedef struct {
        int unsigned     ch;
        logic [TS_W-1:0] ts;
        logic [7:0]      q;
        string           tag;
    } exp_t;

    exp_t            exp_q [NUM_CH][$];
    int              order_q[$];
    bit              rec_order = 1'b0;
    int              n_checks = 0;
    int              n_errs = 0;
    logic [TS_W-1:0] m_ts;

    // time model from R1, R3, R4
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n)    m_ts <= '0;
        else if (sync) m_ts <= '0;
        else           m_ts <= m_ts + 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // driver: arm a strobe for the coming edge, record the expected word
    task automatic arm(input int ch, input logic [7:0] q, input bit keep,
                       input logic [TS_W-1:0] ts, input string tag);
        stb[ch] = 1'b1;
        chg[ch*8 +: 8] = q;
        if (keep) begin
            exp_t e;
            e.ch = ch; e.ts = ts; e.q = q; e.tag = tag;
            exp_q[ch].push_back(e);
        end
    endtask

    task automatic step();
        @(negedge clk);
        stb = '0;
    endtask

    // monitor: compare every accepted word with the head of its channel queue
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_P/4);
            if (rst_n && vld && rdy) begin
                int unsigned ch;
                ch = int'(word[40 +: CH_IDX_W]);
                if (rec_order) order_q.push_back(int'(ch));
                if (exp_q[ch].size() == 0) begin
                    check(1'b0, "R9", "unexpected word", word, 64'h0);
                end else begin
                    exp_t e;
                    logic [63:0] expw;
                    e = exp_q[ch].pop_front();
                    expw = {4'b0000, cfg_addr, CH_IDX_W'(e.ch), 32'(e.ts), e.q};
                    check(word == expw, e.tag, "word (R2 layout)", word, expw);
                end
            end
        end
    end

    initial begin
        #(CLK_P*200000);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(vld == 1'b0, "R1", "valid in reset", 64'(vld), 64'h0);
        check(drops == '0, "R1", "drops in reset", 64'(drops), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: all channels at once, order 0..3 right after reset
        rec_order = 1'b1;
        for (int c = 0; c < NUM_CH; c++) arm(c, 8'h40 + 8'(c), 1'b1, m_ts, "R8");
        step();
        repeat (8) @(negedge clk);
        check(order_q.size() == 4, "R8", "word count", 64'(order_q.size()), 64'd4);
        for (int i = 0; i < 4 && i < order_q.size(); i++)
            check(order_q[i] == i, "R8", "grant order", 64'(order_q[i]), 64'(i));

        // R8: rotation, not fixed priority: expect 1,3,1
        order_q.delete();
        arm(1, 8'h51, 1'b1, m_ts, "R8");
        arm(3, 8'h53, 1'b1, m_ts, "R8");
        step();
        arm(1, 8'h52, 1'b1, m_ts, "R8");
        step();
        repeat (6) @(negedge clk);
        rec_order = 1'b0;
        check(order_q.size() == 3, "R8", "rotation count", 64'(order_q.size()), 64'd3);
        if (order_q.size() == 3) begin
            check(order_q[0] == 1, "R8", "rotation first", 64'(order_q[0]), 64'd1);
            check(order_q[1] == 3, "R8", "rotation second", 64'(order_q[1]), 64'd3);
            check(order_q[2] == 1, "R8", "rotation third", 64'(order_q[2]), 64'd1);
        end

        // R11 latency and R5 capture time
        arm(1, 8'h11, 1'b1, m_ts, "R5");
        step();
        check(vld == 1'b0, "R11", "valid one edge after strobe", 64'(vld), 64'h0);
        @(negedge clk);
        check(vld == 1'b1, "R11", "valid two edges after strobe", 64'(vld), 64'h1);
        repeat (3) @(negedge clk);

        // R7: burst on one channel, every cycle
        for (int i = 0; i < 6; i++) begin
            arm(2, 8'hA0 + 8'(i), 1'b1, m_ts, "R7");
            step();
        end
        repeat (6) @(negedge clk);

        // R9: stall holds the word
        rdy = 1'b0;
        arm(0, 8'hAA, 1'b1, m_ts, "R9");
        step();
        repeat (2) @(negedge clk);
        held = word;
        check(vld == 1'b1, "R9", "valid during stall", 64'(vld), 64'h1);
        @(negedge clk);
        check(vld == 1'b1 && word == held, "R9", "word held", word, held);
        rdy = 1'b1;
        repeat (3) @(negedge clk);

        // R4: hit in the sync cycle keeps old value, next hit sees zero
        sync = 1'b1;
        arm(2, 8'h21, 1'b1, m_ts, "R4");
        step();
        sync = 1'b0;
        arm(3, 8'h22, 1'b1, 8'h00, "R4");
        step();
        repeat (5) @(negedge clk);

        // R3: wrap from all ones to zero
        while (m_ts != 8'hFF) @(negedge clk);
        arm(0, 8'h31, 1'b1, 8'hFF, "R3");
        step();
        arm(1, 8'h32, 1'b1, 8'h00, "R3");
        step();
        repeat (5) @(negedge clk);

        // R6: a different chip address
        cfg_addr = 18'h00001;
        arm(3, 8'h61, 1'b1, m_ts, "R6");
        step();
        repeat (5) @(negedge clk);

        // R10 / R9 / R7: stalled output, fill shared queue then channel queue
        rdy = 1'b0;
        for (int i = 0; i < 20; i++) begin
            arm(0, 8'(i), (i < 12), m_ts, "R10");
            step();
            if (i == 12) begin
                check(drops == 3'd1, "R10", "first drop", 64'(drops), 64'd1);
                arm(1, 8'hB1, 1'b1, m_ts, "R10");
                step();
                check(drops == 3'd1, "R10", "other channel not dropped", 64'(drops), 64'd1);
            end else begin
                @(negedge clk);
            end
        end
        check(drops == 3'd7, "R10", "saturated drop count", 64'(drops), 64'd7);
        check(vld == 1'b1, "R9", "valid while full", 64'(vld), 64'h1);
        rdy = 1'b1;
        repeat (25) @(negedge clk);

        for (int c = 0; c < NUM_CH; c++)
            check(exp_q[c].size() == 0, "R7", "words missing for channel",
                  64'(exp_q[c].size()), 64'h0);
        check(vld == 1'b0, "R9", "valid after drain", 64'(vld), 64'h0);
        check(drops == 3'd7, "R10", "drop count holds", 64'(drops), 64'd7);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule